// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block turns a system clock into the time base of a CAN bit. A programmable prescaler divides the clock into time quanta. Each bit is then built from three segments counted in quanta: a fixed one-quantum sync segment, a programmable first timing segment (propagation and phase-1 merged into one) and a programmable second segment (phase-2). The block gives a one-cycle transmit-point strobe at the start of every bit and a one-cycle sample strobe at the end of the first timing segment, together with the sampled receive level.

The block watches the receive line and reacts only to falls from recessive (1) to dominant (0). While the frame layer reports the bus idle, such a fall triggers a hard sync: the bit restarts at its sync segment, with no limit. Inside a frame, a fall triggers at most one resynchronization per bit. A late edge, in the first segment, lengthens that segment. An early edge, in the second segment, shortens that segment. Both moves are limited by the jump width.

There is no data stream at the edge of this block. Every input and output is a plain level or a single-cycle strobe, so no valid/ready handshake and no back-pressure exist. The frame layer must accept each strobe in the cycle in which it is high. Configuration fields are read at segment boundaries. Recommended settings keep the first segment at 5 quanta or more when the second is 2 quanta and the jump width is 1 quantum.

Top module: `can_bittime_sync`

## Requirements
- R1: One time quantum lasts 2 x (cfg_brp + 1) clock cycles. The tq_stb output is high for the last cycle of each quantum and is never high in two consecutive cycles.
- R2: With no edges, a bit is 1 + (cfg_tseg1 + 1) + (cfg_tseg2 + 1) quanta long. With Q the quantum length in clocks, sample_stb goes high Q x (cfg_tseg1 + 2) cycles after tx_stb, and the next tx_stb comes Q x (cfg_tseg1 + cfg_tseg2 + 3) cycles after it. The two strobes are never high together. The fields cfg_tseg1 (4 bits, 2..16 quanta) and cfg_tseg2 (3 bits) hold the segment length minus one.
- R3: sample_val is updated together with sample_stb. It holds the receive level seen two clocks earlier in the last cycle of the first segment (1 = recessive), and it keeps that value until the next sample.
- R4: rx passes through a two-flop synchronizer. A fall driven into rx in cycle d counts as an edge that belongs to cycle d + 2. A rise has no effect on any timing.
- R5: A late edge in quantum k (counting from 0) of the first segment lengthens that segment by min(k + 1, cfg_sjw + 1) quanta. cfg_sjw is 2 bits and holds the jump width minus one. Its value is taken when the first segment starts.
- R6: An early edge in quantum k of the second segment sets that segment's length, L = cfg_tseg2 + 1, to max(k + 1, L - (cfg_sjw + 1)) quanta. The bit therefore never ends before the current quantum does.
- R7: An edge that falls inside the sync segment changes no timing.
- R8: Only the first edge in a bit may resynchronize. Later edges in the same bit are ignored.
- R9: An edge while bus_idle is 1 is a hard sync. The sync segment restarts in the next cycle with a fresh quantum, whatever the segment and the jump width. No tx_stb is produced for the restarted bit. The sample strobe then follows Q x (cfg_tseg1 + 2) + 1 cycles after the edge cycle.
- R10: During and right after reset, tq_stb, sample_stb and tx_stb are low, and sample_val is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_brp | input | 6 | Prescaler field; quantum = 2 x (value + 1) clocks |
| cfg_tseg1 | input | 4 | First timing segment length minus one |
| cfg_tseg2 | input | 3 | Second timing segment length minus one |
| cfg_sjw | input | 2 | Jump width minus one |
| bus_idle | input | 1 | High when the frame layer sees the bus idle; enables hard sync |
| rx | input | 1 | Receive line, 1 = recessive, 0 = dominant |
| tq_stb | output | 1 | High in the last cycle of each quantum |
| sample_stb | output | 1 | One-cycle strobe at the sample point |
| sample_val | output | 1 | Receive level taken at the latest sample point |
| tx_stb | output | 1 | One-cycle strobe at the start of each bit |

## Verification
The embedded properties check some rules on every cycle. The quantum strobe never repeats on adjacent cycles. The sample and transmit strobes are exclusive, and each follows the right boundary. Only falls are treated as edges. A first segment never grows past its base plus the jump width. A second segment never ends before its current quantum. Once a bit has resynchronized, its length stays fixed. A hard sync never gives a transmit strobe.

Only the bench scenarios can show the exact cycle positions of the strobes. Those are compared against a scoreboard for several prescaler and segment settings. The scenarios also show the amount of each late or early correction, both below and at the jump-width cap. They show that an edge in the sync segment, a second edge in the same bit and a rise are all ignored, and they show where a hard-synced bit lands.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_TS1  = 2'd1,
    SEG_TS2  = 2'd2
  } seg_e;
endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] cfg_brp,
  input  logic             restart,
  output logic             tq_stb
);
  localparam int CW = BRP_W + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  // quantum is 2*(brp+1) clocks: last count is 2*brp+1
  assign last   = {cfg_brp, 1'b1};
  assign tq_stb = rst_n && (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (restart)       cnt <= '0;
    else if (cnt >= last)   cnt <= '0;
    else                    cnt <= cnt + CW'(1);
  end

  AST_TQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tq_stb |=> !tq_stb); // R1
endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rx,
  output logic rx_s,
  output logic edge_fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= rx;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rx_s      = s2;
  assign edge_fall = s3 & ~s2;

  AST_EDGE_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    edge_fall |=> ($past(rx_s) == 1'b0)); // R4
endmodule

// File: rtl/can_bt_segfsm.sv
module can_bt_segfsm
  import can_bt_pkg::*;
#(
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_stb,
  input  logic             edge_fall,
  input  logic             bus_idle,
  input  logic             rx_s,
  input  logic [TS1_W-1:0] cfg_tseg1,
  input  logic [TS2_W-1:0] cfg_tseg2,
  input  logic [SJW_W-1:0] cfg_sjw,
  output logic             hsync,
  output logic             sample_stb,
  output logic             sample_val,
  output logic             tx_stb
);
  localparam int LW = TS1_W + 2;

  seg_e            seg;
  logic [LW-1:0]   qcnt;
  logic [LW-1:0]   len_cur;
  logic [LW-1:0]   ts1_base;
  logic            resynced;
  logic [SJW_W-1:0] sjw_q;
  logic            smp_q, val_q, tx_q;

  logic [LW-1:0]   qn, sj, adj_len;
  logic            adj_done, do_adj, seg_end;

  assign hsync = edge_fall & bus_idle;

  always_comb begin
    qn       = qcnt + LW'(1);
    sj       = LW'(sjw_q) + LW'(1);
    adj_len  = len_cur;
    adj_done = resynced;
    do_adj   = edge_fall & ~bus_idle & ~resynced & (seg != SEG_SYNC);
    if (do_adj) begin
      adj_done = 1'b1;
      if (seg == SEG_TS1) begin
        adj_len = len_cur + ((qn < sj) ? qn : sj);
      end else begin
        adj_len = (len_cur > (qn + sj)) ? (len_cur - sj) : qn;
      end
    end
    seg_end = tq_stb & (qn == adj_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg      <= SEG_SYNC;
      qcnt     <= '0;
      len_cur  <= LW'(1);
      ts1_base <= LW'(1);
      resynced <= 1'b0;
      sjw_q    <= '0;
      smp_q    <= 1'b0;
      val_q    <= 1'b1;
      tx_q     <= 1'b0;
    end else begin
      smp_q <= 1'b0;
      tx_q  <= 1'b0;
      if (hsync) begin
        seg      <= SEG_SYNC;
        qcnt     <= '0;
        len_cur  <= LW'(1);
        resynced <= 1'b1;
      end else if (seg_end) begin
        qcnt <= '0;
        case (seg)
          SEG_SYNC: begin
            seg      <= SEG_TS1;
            len_cur  <= LW'(cfg_tseg1) + LW'(1);
            ts1_base <= LW'(cfg_tseg1) + LW'(1);
            sjw_q    <= cfg_sjw;
            resynced <= adj_done;
          end
          SEG_TS1: begin
            seg      <= SEG_TS2;
            len_cur  <= LW'(cfg_tseg2) + LW'(1);
            resynced <= adj_done;
            smp_q    <= 1'b1;
            val_q    <= rx_s;
          end
          default: begin
            seg      <= SEG_SYNC;
            len_cur  <= LW'(1);
            resynced <= 1'b0;
            tx_q     <= 1'b1;
          end
        endcase
      end else begin
        if (tq_stb) qcnt <= qn;
        len_cur  <= adj_len;
        resynced <= adj_done;
      end
    end
  end

  assign sample_stb = smp_q;
  assign sample_val = val_q;
  assign tx_stb     = tx_q;

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sample_stb, tx_stb})); // R2
  AST_SMP_ON_TQ: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> $past(tq_stb)); // R2
  AST_TX_AFTER_TS2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb |-> ($past(seg) == SEG_TS2 && seg == SEG_SYNC)); // R2
  AST_TS1_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_TS1) |-> (len_cur <= ts1_base + LW'(sjw_q) + LW'(1))); // R5
  AST_TS2_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_TS2) |-> (len_cur > qcnt)); // R6
  AST_SYNC_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_SYNC && $past(seg) == SEG_SYNC && !$past(hsync)) |-> $stable(resynced)); // R7
  AST_ONE_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_TS1 && $past(seg) == SEG_TS1 && $past(resynced) && !$past(hsync))
      |-> (len_cur == $past(len_cur))); // R8
  AST_HSYNC_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> !tx_stb); // R9
endmodule

// File: rtl/can_bittime_sync.sv
module can_bittime_sync #(
  parameter int BRP_W = 6,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] cfg_brp,
  input  logic [TS1_W-1:0] cfg_tseg1,
  input  logic [TS2_W-1:0] cfg_tseg2,
  input  logic [SJW_W-1:0] cfg_sjw,
  input  logic             bus_idle,
  input  logic             rx,
  output logic             tq_stb,
  output logic             sample_stb,
  output logic             sample_val,
  output logic             tx_stb
);
  logic rx_s, edge_fall, hsync;

  can_bt_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx        (rx),
    .rx_s      (rx_s),
    .edge_fall (edge_fall)
  );

  can_bt_prescaler #(.BRP_W(BRP_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_brp (cfg_brp),
    .restart (hsync),
    .tq_stb  (tq_stb)
  );

  can_bt_segfsm #(.TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tq_stb     (tq_stb),
    .edge_fall  (edge_fall),
    .bus_idle   (bus_idle),
    .rx_s       (rx_s),
    .cfg_tseg1  (cfg_tseg1),
    .cfg_tseg2  (cfg_tseg2),
    .cfg_sjw    (cfg_sjw),
    .hsync      (hsync),
    .sample_stb (sample_stb),
    .sample_val (sample_val),
    .tx_stb     (tx_stb)
  );

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!sample_stb && !tx_stb)); // R10
endmodule

// File: tb/can_bittime_sync_test.sv
module can_bittime_sync_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cfg_brp = 6'd1;
  logic [3:0] cfg_tseg1 = 4'd4;
  logic [2:0] cfg_tseg2 = 3'd2;
  logic [1:0] cfg_sjw = 2'd1;
  logic       bus_idle = 1'b0;
  logic       rx = 1'b1;
  logic       tq_stb, sample_stb, sample_val, tx_stb;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  int    qs_cyc[$];
  bit    qs_val[$];
  string qs_tag[$];
  int    qt_cyc[$];
  string qt_tag[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  can_bittime_sync uut (
    .clk(clk), .rst_n(rst_n), .cfg_brp(cfg_brp), .cfg_tseg1(cfg_tseg1),
    .cfg_tseg2(cfg_tseg2), .cfg_sjw(cfg_sjw), .bus_idle(bus_idle), .rx(rx),
    .tq_stb(tq_stb), .sample_stb(sample_stb), .sample_val(sample_val), .tx_stb(tx_stb)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expectations as strobes appear
  always @(negedge clk) begin
    if (rst_n && sample_stb && qs_cyc.size() > 0) begin
      check({qs_tag[0], " sample cycle"}, cyc, qs_cyc[0]);
      check({qs_tag[0], " sample value"}, int'(sample_val), int'(qs_val[0]));
      void'(qs_cyc.pop_front()); void'(qs_val.pop_front()); void'(qs_tag.pop_front());
    end
    if (rst_n && tx_stb && qt_cyc.size() > 0) begin
      check({qt_tag[0], " tx cycle"}, cyc, qt_cyc[0]);
      void'(qt_cyc.pop_front()); void'(qt_tag.pop_front());
    end
  end

  task automatic push_smp(input int c, input bit v, input string tag);
    qs_cyc.push_back(c); qs_val.push_back(v); qs_tag.push_back(tag);
  endtask

  task automatic push_tx(input int c, input string tag);
    qt_cyc.push_back(c); qt_tag.push_back(tag);
  endtask

  // returns the cycle in which tx_stb was high, then steps past it
  task automatic wait_bit(output int c0);
    do @(negedge clk); while (!tx_stb);
    c0 = cyc;
    @(posedge clk);
  endtask

  task automatic drive(input int d, input bit v);
    do @(negedge clk); while (cyc < d);
    rx = v;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 3000 && (qs_cyc.size() + qt_cyc.size()) > 0; i++) @(negedge clk);
    check({tag, " drained"}, qs_cyc.size() + qt_cyc.size(), 0);
    qs_cyc.delete(); qs_val.delete(); qs_tag.delete(); qt_cyc.delete(); qt_tag.delete();
  endtask

  task automatic setcfg(input int b, input int t1, input int t2, input int s);
    int c;
    cfg_brp = 6'(b); cfg_tseg1 = 4'(t1); cfg_tseg2 = 3'(t2); cfg_sjw = 2'(s);
    wait_bit(c); wait_bit(c);
  endtask

  task automatic measure_tq(input int expq, input string tag);
    int t1;
    do @(negedge clk); while (!tq_stb);
    t1 = cyc;
    do @(negedge clk); while (!tq_stb);
    check(tag, cyc - t1, expq);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    check("R10 reset strobes", int'({tq_stb, sample_stb, tx_stb}), 0);
    check("R10 reset sample_val", int'(sample_val), 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", int'({sample_stb, tx_stb}), 0);

    // Q=4, T1=5, T2=3, SJW=2
    setcfg(1, 4, 2, 1);
    measure_tq(4, "R1 quantum brp=1");

    wait_bit(c0);
    push_smp(c0 + 24, 1'b1, "R2 nominal"); push_tx(c0 + 36, "R2 nominal");
    drain("R2 nominal");

    wait_bit(c0);
    push_smp(c0 + 28, 1'b1, "R5 late k0"); push_tx(c0 + 40, "R5 late k0");
    drive(c0 + 3, 1'b0); drive(c0 + 8, 1'b1);
    drain("R5 late k0");

    wait_bit(c0);
    push_smp(c0 + 32, 1'b1, "R5 late capped"); push_tx(c0 + 44, "R5 late capped");
    drive(c0 + 15, 1'b0); drive(c0 + 19, 1'b1);
    drain("R5 late capped");

    wait_bit(c0);
    push_smp(c0 + 24, 1'b1, "R6 early"); push_tx(c0 + 28, "R6 early");
    drive(c0 + 23, 1'b0); drive(c0 + 27, 1'b1);
    drain("R6 early");

    wait_bit(c0);
    push_smp(c0 + 24, 1'b1, "R7 sync edge"); push_tx(c0 + 36, "R7 sync edge");
    push_smp(c0 + 60, 1'b1, "R7 sync edge"); push_tx(c0 + 72, "R7 sync edge");
    drive(c0 + 35, 1'b0); drive(c0 + 40, 1'b1);
    drain("R7 sync edge");

    wait_bit(c0);
    push_smp(c0 + 28, 1'b1, "R8 second edge"); push_tx(c0 + 40, "R8 second edge");
    drive(c0 + 3, 1'b0); drive(c0 + 8, 1'b1);
    drive(c0 + 15, 1'b0); drive(c0 + 19, 1'b1);
    drain("R8 second edge");

    wait_bit(c0);
    push_smp(c0 + 24, 1'b1, "R4 rise ignored"); push_tx(c0 + 36, "R4 rise ignored");
    drive(c0 + 1, 1'b0); drive(c0 + 8, 1'b1);
    drain("R4 rise ignored");

    wait_bit(c0);
    push_smp(c0 + 24, 1'b0, "R3 dominant sample"); push_tx(c0 + 36, "R3 dominant sample");
    drive(c0 + 1, 1'b0); drive(c0 + 26, 1'b1);
    drain("R3 dominant sample");

    wait_bit(c0);
    push_smp(c0 + 39, 1'b1, "R9 hard sync"); push_tx(c0 + 51, "R9 hard sync");
    drive(c0 + 12, 1'b0); bus_idle = 1'b1;
    drive(c0 + 15, 1'b1); bus_idle = 1'b0;
    drain("R9 hard sync");

    // SJW=1: early edge shortens by one quantum only
    setcfg(1, 4, 2, 0);
    wait_bit(c0);
    push_smp(c0 + 24, 1'b1, "R6 early sjw1"); push_tx(c0 + 32, "R6 early sjw1");
    drive(c0 + 23, 1'b0); drive(c0 + 27, 1'b1);
    drain("R6 early sjw1");

    // Q=8
    setcfg(3, 4, 2, 1);
    measure_tq(8, "R1 quantum brp=3");
    wait_bit(c0);
    push_smp(c0 + 48, 1'b1, "R2 nominal Q8"); push_tx(c0 + 72, "R2 nominal Q8");
    drain("R2 nominal Q8");

    // Q=2, T1=16, T2=8
    setcfg(0, 15, 7, 3);
    measure_tq(2, "R1 quantum brp=0");
    wait_bit(c0);
    push_smp(c0 + 34, 1'b1, "R2 long segs"); push_tx(c0 + 50, "R2 long segs");
    drain("R2 long segs");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule